// File: doc/BRIEF.md
# Write-Leveling Strobe Edge Finder

The block trains the write strobe of every byte lane so that it lines up with the memory clock. Each lane's strobe is looped back and sampled on that lane's data line. For each lane the block finds the strobe delay at which this sampled value changes from low to high. It moves each lane's delay through an external delay stepper, one position per request. Each lane's delay is tracked as a linear position from 0 to `POS_MAX`.

The search runs in two passes. Each iteration asks an external sampler for a burst of `NSAMP` samples. The sampler returns, for every lane, how many of those samples were high. In pass 0 the block moves every lane that has not finished down one position, until each lane reads all-low. It then clears its finished mask and starts pass 1. In pass 1 it moves lanes up one position until each one reads all-high. Because each lane first reaches a solid low and then a solid high, it must have crossed a rising transition. When both passes succeed, the block stores each lane's final strobe position. It also stores a data-delay position, which is the strobe position plus a fixed offset chosen by the speed grade.

The control is a state machine with seven states:
- `ST_IDLE` waits for `start`.
- `ST_REQ` pulses the sample request.
- `ST_WAIT_CNT` waits for the counts.
- `ST_STEP` pulses the step requests.
- `ST_WAIT_ACK` waits for the per-lane acknowledgements.
- `ST_DONE` and `ST_FAIL` hold the final result.

The transitions are:
- `start` takes IDLE, DONE or FAIL to REQ.
- REQ goes to WAIT_CNT after one cycle.
- WAIT_CNT goes to FAIL if a lane is blocked.
- WAIT_CNT goes to REQ when pass 0 completes.
- WAIT_CNT goes to DONE when pass 1 completes.
- In every other case, WAIT_CNT goes to STEP.
- STEP goes to WAIT_ACK after one cycle.
- WAIT_ACK goes to REQ once every stepped lane has acknowledged.

Top module: `wl_edge_finder`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `samp_req`, `step_dn`, `step_up`, `err_lanes`, `lane_pos` and `lane_dq` are all zero.
- R2: When `start` is sampled in idle, done or failed, the block loads each lane's position from `init_pos` (lane i at bits [i*PW +: PW]) and latches `grade`. It then drives `busy` and a one-cycle `samp_req` in the next cycle.
- R3: In pass 0, when the counts arrive, a lane that has not finished and whose count (lane i at bits [i*CW +: CW]) is 0 becomes finished. Every other unfinished lane receives a one-cycle `step_dn` pulse in the cycle after `samp_valid`. Its position falls by one.
- R4: In pass 1, the finished mask starts empty. An unfinished lane whose count equals `NSAMP` becomes finished. Every other unfinished lane receives a one-cycle `step_up` pulse in the cycle after `samp_valid`. Its position rises by one.
- R5: A finished lane receives no step. When every lane has finished, pass 0 issues a new `samp_req` in the next cycle and begins pass 1. At the end of pass 1, `done` rises in the next cycle and each lane's final strobe position appears on `lane_pos`.
- R6: After a step, the next `samp_req` comes in the cycle after the last `step_ack` of the lanes that were stepped. Acknowledgements may arrive in any cycles after the step pulse.
- R7: The block raises `err` in the cycle after `samp_valid` if any lane must step down at position 0 in pass 0, or step up at `POS_MAX` in pass 1. `err_lanes` marks each such lane. No step is issued in that case, and the block stops.
- R8: On `done`, `lane_dq` lane i equals `lane_pos` lane i plus an offset chosen by `grade`: 0 gives 39, 1 gives 32, 2 gives 42, and 3 gives 39.
- R9: `start` has no effect while `busy` is high. `done` or `err`, together with the result outputs, hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search |
| grade | input | 2 | Speed grade that selects the data-delay offset |
| init_pos | input | LANES*PW (48) | Initial strobe position per lane |
| samp_req | output | 1 | One-cycle request for a burst of samples |
| samp_valid | input | 1 | Counts on `samp_cnt` are valid |
| samp_cnt | input | LANES*CW (24) | Per-lane count of high samples |
| step_dn | output | LANES (8) | One-cycle step-down request per lane |
| step_up | output | LANES (8) | One-cycle step-up request per lane |
| step_ack | input | LANES (8) | Per-lane step acknowledgement |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished successfully |
| err | output | 1 | Search aborted at a range end |
| err_lanes | output | LANES (8) | Lanes that hit the range end |
| lane_pos | output | LANES*PW (48) | Final strobe position per lane |
| lane_dq | output | LANES*DW (56) | Final data-delay position per lane |

## Verification
A wrong finished mask or a wrong pass flag shows up within one cycle of the next `samp_valid`. The `step_dn` or `step_up` mask is then wrong, or a lane is stepped in the wrong direction. Either case is caught by the per-cycle comparison against the bench's model of the search. A wrong position register first shows up as a changed count, and at the end as a `lane_pos` that is not the edge location plus two. A lost acknowledgement is caught when the next `samp_req` is late or early relative to the last `step_ack`. An error mask is caught when `err` rises in the wrong cycle or marks the wrong lanes.

// File: rtl/wl_edge_pkg.sv
package wl_edge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT_CNT,
        ST_STEP,
        ST_WAIT_ACK,
        ST_DONE,
        ST_FAIL
    } wl_state_e;

endpackage

// File: rtl/wl_lane_judge.sv
// Per-lane decision taken when a count burst returns.
module wl_lane_judge #(
    parameter int CW      = 3,
    parameter int PW      = 6,
    parameter int NSAMP   = 5,
    parameter int POS_MAX = 63
) (
    input  logic [CW-1:0] cnt,
    input  logic [PW-1:0] pos,
    input  logic          pass1,
    input  logic          lane_done,
    output logic          hit,
    output logic          need,
    output logic          blocked
);
    localparam logic [CW-1:0] FULL = CW'(NSAMP);
    localparam logic [PW-1:0] TOP  = PW'(POS_MAX);

    always_comb begin
        // pass 0 looks for all-low, pass 1 looks for all-high
        hit     = pass1 ? (cnt == FULL) : (cnt == '0);
        need    = !lane_done && !hit;
        blocked = need && (pass1 ? (pos == TOP) : (pos == '0));
    end
endmodule

// File: rtl/wl_lane_pos.sv
// Linear position mirror of one lane's strobe delay.
module wl_lane_pos #(
    parameter int PW      = 6,
    parameter int POS_MAX = 63
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] init,
    input  logic          dn,
    input  logic          up,
    output logic [PW-1:0] pos
);
    localparam logic [PW-1:0] TOP = PW'(POS_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (load) pos <= init;
        else if (dn)   pos <= pos - PW'(1);
        else if (up)   pos <= pos + PW'(1);
    end

    // R7: the controller never steps below the floor or above the top
    p_dn_above_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dn |-> (pos != '0));
    p_up_below_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> (pos != TOP));
endmodule

// File: rtl/wl_seq_fsm.sv
// Pass sequencing, finished mask and step/ack bookkeeping.
module wl_seq_fsm
    import wl_edge_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             samp_valid,
    input  logic [LANES-1:0] hit,
    input  logic [LANES-1:0] need,
    input  logic [LANES-1:0] blocked,
    input  logic [LANES-1:0] step_ack,
    output logic             pass1,
    output logic [LANES-1:0] done_mask,
    output logic             samp_req,
    output logic [LANES-1:0] step_dn,
    output logic [LANES-1:0] step_up,
    output logic             load,
    output logic             latch,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [LANES-1:0] err_lanes
);
    wl_state_e        state_q, state_d;
    logic             pass1_q;
    logic [LANES-1:0] done_q, pend_q, errl_q;
    logic             accept, all_fin, any_blk, eval;

    always_comb begin
        accept  = start && (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);
        all_fin = &(done_q | hit);
        any_blk = |blocked;
        eval    = (state_q == ST_WAIT_CNT) && samp_valid;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) state_d = ST_REQ;
            ST_REQ:                    state_d = ST_WAIT_CNT;
            ST_WAIT_CNT: begin
                if (samp_valid) begin
                    if (any_blk)      state_d = ST_FAIL;
                    else if (all_fin) state_d = pass1_q ? ST_DONE : ST_REQ;
                    else              state_d = ST_STEP;
                end
            end
            ST_STEP:                   state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if ((pend_q & ~step_ack) == '0) state_d = ST_REQ;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pass, finished mask, pending acks, error lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass1_q <= 1'b0;
            done_q  <= '0;
            pend_q  <= '0;
            errl_q  <= '0;
        end else if (accept) begin
            pass1_q <= 1'b0;
            done_q  <= '0;
            pend_q  <= '0;
            errl_q  <= '0;
        end else if (eval) begin
            if (any_blk) begin
                errl_q <= blocked;
            end else if (all_fin) begin
                if (!pass1_q) begin
                    pass1_q <= 1'b1;
                    done_q  <= '0;
                end else begin
                    done_q  <= '1;
                end
            end else begin
                done_q <= done_q | hit;
                pend_q <= need;
            end
        end else if (state_q == ST_WAIT_ACK) begin
            pend_q <= pend_q & ~step_ack;
        end
    end

    // outputs
    always_comb begin
        samp_req  = (state_q == ST_REQ);
        step_dn   = (state_q == ST_STEP && !pass1_q) ? pend_q : '0;
        step_up   = (state_q == ST_STEP &&  pass1_q) ? pend_q : '0;
        load      = accept;
        latch     = eval && !any_blk && all_fin && pass1_q;
        busy      = !(state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);
        done      = (state_q == ST_DONE);
        err       = (state_q == ST_FAIL);
        err_lanes = errl_q;
        pass1     = pass1_q;
        done_mask = done_q;
    end

    // R6: a fresh burst is requested only once every step was acknowledged
    p_req_after_acks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        samp_req |-> (pend_q == '0));
    // R5: finished lanes are never stepped
    p_step_skips_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> ((pend_q & done_q) == '0));
    // R5: success implies every lane finished pass 1
    p_done_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&done_q && pass1_q));
    // R7: a failed search is quiet
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (step_dn == '0 && step_up == '0 && !samp_req && errl_q != '0));
endmodule

// File: rtl/wl_result.sv
// Final strobe and data-delay registers.
module wl_result #(
    parameter int LANES = 8,
    parameter int PW    = 6,
    parameter int DW    = 7,
    parameter int OFF0  = 39,
    parameter int OFF1  = 32,
    parameter int OFF2  = 42
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [1:0]          grade_in,
    input  logic                latch,
    input  logic [LANES*PW-1:0] pos_flat,
    output logic [LANES*PW-1:0] lane_pos,
    output logic [LANES*DW-1:0] lane_dq
);
    logic [1:0]    grade_q;
    logic [DW-1:0] off;

    always_ff @(posedge clk) begin
        if (!rst_n)    grade_q <= '0;
        else if (load) grade_q <= grade_in;
    end

    always_comb begin
        unique case (grade_q)
            2'd1:    off = DW'(OFF1);
            2'd2:    off = DW'(OFF2);
            default: off = DW'(OFF0);
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_res
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_pos[i*PW +: PW] <= '0;
                lane_dq[i*DW +: DW]  <= '0;
            end else if (latch) begin
                lane_pos[i*PW +: PW] <= pos_flat[i*PW +: PW];
                lane_dq[i*DW +: DW]  <= DW'(pos_flat[i*PW +: PW]) + off;
            end
        end
    end
endmodule

// File: rtl/wl_edge_finder.sv
module wl_edge_finder #(
    parameter int LANES   = 8,
    parameter int NSAMP   = 5,
    parameter int POS_MAX = 63,
    parameter int OFF0    = 39,
    parameter int OFF1    = 32,
    parameter int OFF2    = 42,
    localparam int PW     = $clog2(POS_MAX + 1),
    localparam int CW     = $clog2(NSAMP + 1),
    localparam int OFFM   = (OFF0 > OFF1) ? ((OFF0 > OFF2) ? OFF0 : OFF2)
                                          : ((OFF1 > OFF2) ? OFF1 : OFF2),
    localparam int DW     = $clog2(POS_MAX + OFFM + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          grade,
    input  logic [LANES*PW-1:0] init_pos,
    output logic                samp_req,
    input  logic                samp_valid,
    input  logic [LANES*CW-1:0] samp_cnt,
    output logic [LANES-1:0]    step_dn,
    output logic [LANES-1:0]    step_up,
    input  logic [LANES-1:0]    step_ack,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [LANES-1:0]    err_lanes,
    output logic [LANES*PW-1:0] lane_pos,
    output logic [LANES*DW-1:0] lane_dq
);
    logic                pass1, load, latch;
    logic [LANES-1:0]    done_mask, hit, need, blocked;
    logic [LANES*PW-1:0] pos_flat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        wl_lane_judge #(.CW(CW), .PW(PW), .NSAMP(NSAMP), .POS_MAX(POS_MAX)) u_judge (
            .cnt       (samp_cnt[i*CW +: CW]),
            .pos       (pos_flat[i*PW +: PW]),
            .pass1     (pass1),
            .lane_done (done_mask[i]),
            .hit       (hit[i]),
            .need      (need[i]),
            .blocked   (blocked[i])
        );
        wl_lane_pos #(.PW(PW), .POS_MAX(POS_MAX)) u_pos (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .init  (init_pos[i*PW +: PW]),
            .dn    (step_dn[i]),
            .up    (step_up[i]),
            .pos   (pos_flat[i*PW +: PW])
        );
    end

    wl_seq_fsm #(.LANES(LANES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .samp_valid (samp_valid),
        .hit        (hit),
        .need       (need),
        .blocked    (blocked),
        .step_ack   (step_ack),
        .pass1      (pass1),
        .done_mask  (done_mask),
        .samp_req   (samp_req),
        .step_dn    (step_dn),
        .step_up    (step_up),
        .load       (load),
        .latch      (latch),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .err_lanes  (err_lanes)
    );

    wl_result #(.LANES(LANES), .PW(PW), .DW(DW),
                .OFF0(OFF0), .OFF1(OFF1), .OFF2(OFF2)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .grade_in (grade),
        .latch    (latch),
        .pos_flat (pos_flat),
        .lane_pos (lane_pos),
        .lane_dq  (lane_dq)
    );

    // R2: a burst request never overlaps a step pulse
    p_req_not_with_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        samp_req |-> (step_dn == '0 && step_up == '0));
endmodule

// File: tb/wl_edge_finder_test.sv
module wl_edge_finder_test;
    localparam int CLK_NS = 10;
    localparam int LANES  = 8;
    localparam int PW     = 6;
    localparam int CW     = 3;
    localparam int DW     = 7;
    localparam int NS     = 5;
    localparam int PMAX   = 63;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [1:0]          grade = '0;
    logic [LANES*PW-1:0] init_pos = '0;
    logic                samp_valid = 1'b0;
    logic [LANES*CW-1:0] samp_cnt = '0;
    logic [LANES-1:0]    step_ack = '0;
    logic                samp_req, busy, done, err;
    logic [LANES-1:0]    step_dn, step_up, err_lanes;
    logic [LANES*PW-1:0] lane_pos;
    logic [LANES*DW-1:0] lane_dq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    wl_edge_finder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .grade(grade), .init_pos(init_pos),
        .samp_req(samp_req), .samp_valid(samp_valid), .samp_cnt(samp_cnt),
        .step_dn(step_dn), .step_up(step_up), .step_ack(step_ack),
        .busy(busy), .done(done), .err(err), .err_lanes(err_lanes),
        .lane_pos(lane_pos), .lane_dq(lane_dq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // sampled level model: solid low well before the edge, solid high well after
    function automatic int cnt_of(input int p, input int e);
        if (p < e - 2) return 0;
        if (p > e + 1) return NS;
        return p - e + 3;
    endfunction

    function automatic int off_of(input int g);
        case (g)
            1:       return 32;
            2:       return 42;
            default: return 39;
        endcase
    endfunction

    task automatic run_case(input int init[LANES], input int edg[LANES], input int g,
                            input int exp_err, input bit inject);
        int mpos[LANES];
        int acd[LANES];
        bit mdone[LANES];
        bit mpass1, e_req, e_done, e_err, fin, injected, anyblk, alld;
        logic [LANES-1:0] e_dn, e_up;
        int scd, outst, iter, cyc, c;
        @(negedge clk);
        grade = 2'(g);
        for (int i = 0; i < LANES; i++) begin
            init_pos[i*PW +: PW] = PW'(init[i]);
            mpos[i] = init[i];
            mdone[i] = 1'b0;
            acd[i] = 0;
        end
        start = 1'b1;
        mpass1 = 0; e_req = 1; e_done = 0; e_err = 0; e_dn = '0; e_up = '0;
        scd = 0; outst = 0; iter = 0; cyc = 0; fin = 0; injected = 0;
        while (!fin) begin
            @(negedge clk);
            start = 1'b0; samp_valid = 1'b0; step_ack = '0;
            cyc++;
            if (cyc == 1) chk(busy === 1'b1, "R2", "busy after start", busy, 1);
            chk(samp_req === e_req, "R6", "samp_req", samp_req, e_req);
            chk(step_dn === e_dn, "R3", "step_dn", step_dn, e_dn);
            chk(step_up === e_up, "R4", "step_up", step_up, e_up);
            if (e_done) begin
                chk(done === 1'b1, "R5", "done", done, 1);
                fin = 1;
            end else if (e_err) begin
                chk(err === 1'b1, "R7", "err", err, 1);
                chk(int'(err_lanes) == exp_err, "R7", "err_lanes", err_lanes, exp_err);
                fin = 1;
            end else begin
                chk(done === 1'b0 && err === 1'b0, "R7", "early terminal flag", {done, err}, 0);
            end
            if (cyc > 20000) begin
                chk(1'b0, "R5", "case timeout", cyc, 20000);
                fin = 1;
            end
            if (!fin) begin
                e_req = 0; e_dn = '0; e_up = '0;
                // deliver a pending count burst
                if (scd > 0) begin
                    scd--;
                    if (scd == 0) begin
                        samp_valid = 1'b1;
                        anyblk = 0; alld = 1;
                        for (int i = 0; i < LANES; i++) begin
                            bit h, n;
                            c = cnt_of(mpos[i], edg[i]);
                            samp_cnt[i*CW +: CW] = CW'(c);
                            h = mpass1 ? (c == NS) : (c == 0);
                            n = !mdone[i] && !h;
                            if (n && (mpass1 ? (mpos[i] == PMAX) : (mpos[i] == 0))) anyblk = 1;
                            if (!(mdone[i] || h)) alld = 0;
                        end
                        if (anyblk) e_err = 1;
                        else if (alld) begin
                            if (!mpass1) begin
                                mpass1 = 1;
                                for (int i = 0; i < LANES; i++) mdone[i] = 0;
                                e_req = 1;
                            end else e_done = 1;
                        end else begin
                            for (int i = 0; i < LANES; i++) begin
                                bit h;
                                c = cnt_of(mpos[i], edg[i]);
                                h = mpass1 ? (c == NS) : (c == 0);
                                if (!mdone[i] && !h) begin
                                    if (mpass1) e_up[i] = 1'b1; else e_dn[i] = 1'b1;
                                end
                                if (h) mdone[i] = 1;
                            end
                        end
                    end
                end
                // deliver acknowledgements
                for (int i = 0; i < LANES; i++) begin
                    if (acd[i] > 0) begin
                        acd[i]--;
                        if (acd[i] == 0) begin
                            step_ack[i] = 1'b1;
                            outst--;
                            if (outst == 0) e_req = 1;
                        end
                    end
                end
                // register new requests seen this cycle
                if (samp_req) scd = 1 + (iter % 3);
                for (int i = 0; i < LANES; i++) begin
                    if (step_dn[i] || step_up[i]) begin
                        mpos[i] = step_dn[i] ? mpos[i] - 1 : mpos[i] + 1;
                        acd[i] = 1 + ((i * 3 + iter) % 4);
                        outst++;
                    end
                end
                if ((step_dn | step_up) != '0) iter++;
                // R9: start while busy must leave the search untouched
                if (inject && !injected && outst > 0) begin
                    start = 1'b1;
                    injected = 1;
                end
            end
        end
        if (exp_err < 0 && e_done) begin
            for (int i = 0; i < LANES; i++) begin
                chk(int'(lane_pos[i*PW +: PW]) == edg[i] + 2, "R5", "lane_pos",
                    lane_pos[i*PW +: PW], edg[i] + 2);
                chk(int'(lane_dq[i*DW +: DW]) == edg[i] + 2 + off_of(g), "R8", "lane_dq",
                    lane_dq[i*DW +: DW], edg[i] + 2 + off_of(g));
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(done === e_done && err === e_err && samp_req === 1'b0 && busy === 1'b0,
                "R9", "terminal hold", {done, err, samp_req, busy}, {e_done, e_err, 2'b00});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 0 && done === 0 && err === 0 && samp_req === 0, "R1", "control outputs",
            {busy, done, err, samp_req}, 0);
        chk(step_dn === '0 && step_up === '0 && err_lanes === '0, "R1", "step/err outputs",
            {step_dn, step_up, err_lanes}, 0);
        chk(lane_pos === '0 && lane_dq === '0, "R1", "result outputs", lane_pos, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4 R5 R8 R9: grade 0, start injected mid-run
        run_case('{30,30,30,30,30,30,30,30}, '{10,15,20,25,30,12,40,8}, 0, -1, 1);
        // R8: grade 1, mixed starting points
        run_case('{5,10,60,33,0,20,45,2}, '{3,12,50,33,4,22,44,5}, 1, -1, 0);
        // R8: grade 2, all start at the top
        run_case('{63,63,63,63,63,63,63,63}, '{61,3,33,47,18,55,26,9}, 2, -1, 0);
        // R7: two lanes blocked at position 0 in pass 0
        run_case('{2,2,2,2,2,2,2,2}, '{1,2,20,20,20,20,20,20}, 3, 3, 0);
        // R7: lane 5 blocked at the top in pass 1
        run_case('{50,50,50,50,50,50,50,50}, '{20,20,20,20,20,62,61,20}, 0, 32, 0);
        // R8: grade 3, pass 0 finishes at once
        run_case('{0,0,0,0,0,0,0,0}, '{3,4,5,6,7,8,9,10}, 3, -1, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule